// File: doc/BRIEF.md
# Dual-Loop Phase-Frequency Detector with Lock Monitor

This block compares timing for the two loops of a dual synthesizer, called main and auxiliary. For each loop it takes the divided reference pulse train and the divided feedback pulse train. Both are active-low pulses that idle high and are synchronous to a fast reference clock. It produces a raise request (`*_up`) and a lower request (`*_dn`), which drive the analog charge pumps outside the block. Each loop uses a two-flip-flop detector. A falling edge of the reference sets the raise flag and a falling edge of the feedback sets the lower flag. When both flags are set, they are cleared together on the following reference clock edge. That one-cycle overlap keeps small phase errors out of a dead zone.

Lock is judged digitally. A lock meter counts the reference clock cycles during which only one flag of a loop is set. A comparison is good when that one-sided width stays below `SKEW_LIMIT` cycles. A loop is declared locked after `LOCK_COUNT` good comparisons in a row. It loses lock as soon as a one-sided pulse reaches the limit. A loop whose enable is low keeps its flags cleared and counts as locked.

A single registered monitor pin carries the lock state of both loops combined. A 2-bit select can instead route one of three divider pulse trains to the pin, so the divide ratios can be observed.

Top module: `pfd_dual_lock`

## Requirements
- R1: A sampled falling edge on a loop's reference input sets that loop's `up` output, and a sampled falling edge on its feedback input sets `dn`. Each output rises at the first clock edge that sees the input low after a high sample.
- R2: When `up` and `dn` of a loop are both high, both go low at the next clock edge, so they are high together for exactly one cycle. A falling edge that arrives in that clearing cycle is dropped.
- R3: While a loop's enable is 0, its `up` and `dn` are low from the next clock edge on, whatever its divider inputs do.
- R4: A comparison of a loop is good when its one-sided pulse lasted fewer than `SKEW_LIMIT` cycles (default 1). The loop becomes locked after `LOCK_COUNT` (default 4) consecutive good comparisons.
- R5: A locked loop loses lock at the clock edge after its one-sided pulse width reaches `SKEW_LIMIT`, even if the other edge never arrives.
- R6: With select 00, `lock_mon` is registered from the AND of the two loop lock states, where a loop with enable 0 counts as locked. It follows with one cycle of latency.
- R7: `lock_mon` is registered with one cycle of latency from the input chosen by `test_sel`. Select 01 gives the inverted main reference input (idle low, high pulses). Select 10 gives the auxiliary feedback input and select 11 gives the main feedback input (both idle high, low pulses).
- R8: Synchronous active-high reset clears all four pump outputs and `lock_mon` to 0, and the edge detectors treat both inputs as idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| main_en | input | 1 | Main loop enable |
| aux_en | input | 1 | Auxiliary loop enable |
| main_ref_div | input | 1 | Main reference divider pulse, active low |
| main_fb_div | input | 1 | Main feedback divider pulse, active low |
| aux_ref_div | input | 1 | Auxiliary reference divider pulse, active low |
| aux_fb_div | input | 1 | Auxiliary feedback divider pulse, active low |
| test_sel | input | 2 | Monitor pin source select |
| main_up | output | 1 | Main loop raise request |
| main_dn | output | 1 | Main loop lower request |
| aux_up | output | 1 | Auxiliary loop raise request |
| aux_dn | output | 1 | Auxiliary loop lower request |
| lock_mon | output | 1 | Combined lock or selected divider monitor |

## Verification
Several rules are checked on every cycle by assertions. The one-cycle clearing of a both-set pair is checked, and so is the forced clearing of a disabled loop. The assertions also check that the pin reads locked when both loops are disabled, and that the pin follows the reference and main-feedback inputs in those monitor modes. Only the bench scenarios can show the lock history. That covers reaching lock after the required run of aligned comparisons, losing it after a skewed or missing edge, and dropping an edge that arrives in the clearing cycle. The bench checks these against a behavioural model on every clock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    MON_LOCK = 2'b00,
    MON_REF  = 2'b01,
    MON_AUX  = 2'b10,
    MON_MAIN = 2'b11
  } mon_sel_e;

  localparam int unsigned NUM_LOOPS = 2;
  localparam int unsigned LOOP_MAIN = 0;
  localparam int unsigned LOOP_AUX  = 1;
endpackage

// File: rtl/pfd_detector.sv
// Two-flag phase-frequency detector, flags cleared one clock after both set.
module pfd_detector (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ref_n,
  input  logic fb_n,
  output logic up,
  output logic dn
);
  logic ref_q, fb_q;
  logic ref_fall, fb_fall, both_set;

  assign ref_fall = ref_q & ~ref_n;
  assign fb_fall  = fb_q & ~fb_n;
  assign both_set = up & dn;

  // Previous-level samples are tracked even while disabled.
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b1;
      fb_q  <= 1'b1;
    end else begin
      ref_q <= ref_n;
      fb_q  <= fb_n;
    end
  end

  // Clearing has priority over a new set.
  always_ff @(posedge clk) begin
    if (rst || !en || both_set) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up | ref_fall;
      dn <= dn | fb_fall;
    end
  end
endmodule

// File: rtl/pfd_lock_meter.sv
// Measures one-sided pulse width and tracks a run of good comparisons.
module pfd_lock_meter #(
  parameter int unsigned SKEW_LIMIT = 1,
  parameter int unsigned LOCK_COUNT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic up,
  input  logic dn,
  output logic loop_ok
);
  localparam int unsigned SKEW_W   = $clog2(SKEW_LIMIT + 1);
  localparam int unsigned STREAK_W = $clog2(LOCK_COUNT + 1);
  localparam logic [SKEW_W-1:0]   SKEW_MAX   = SKEW_W'(SKEW_LIMIT);
  localparam logic [STREAK_W-1:0] STREAK_MAX = STREAK_W'(LOCK_COUNT);
  localparam logic [STREAK_W-1:0] STREAK_PRE = STREAK_W'(LOCK_COUNT - 1);

  logic [SKEW_W-1:0]   width_q;
  logic [STREAK_W-1:0] streak_q;
  logic                locked_q;
  logic                both_set, one_side, violated;

  assign both_set = up & dn;
  assign one_side = up ^ dn;
  assign violated = (width_q == SKEW_MAX);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      width_q <= '0;
    end else if (both_set) begin
      width_q <= '0;
    end else if (one_side && !violated) begin
      width_q <= width_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      streak_q <= '0;
      locked_q <= 1'b0;
    end else if (violated) begin
      streak_q <= '0;
      locked_q <= 1'b0;
    end else if (both_set) begin
      if (streak_q != STREAK_MAX) streak_q <= streak_q + 1'b1;
      if (streak_q >= STREAK_PRE) locked_q <= 1'b1;
    end
  end

  assign loop_ok = locked_q | ~en;
endmodule

// File: rtl/pfd_mon_mux.sv
// Registered selector for the shared lock/monitor pin.
module pfd_mon_mux
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       main_ok,
  input  logic       aux_ok,
  input  logic       main_ref_n,
  input  logic       aux_fb_n,
  input  logic       main_fb_n,
  output logic       mon
);
  mon_sel_e sel_e;
  logic     mon_d;

  assign sel_e = mon_sel_e'(sel);

  always_comb begin
    unique case (sel_e)
      MON_LOCK: mon_d = main_ok & aux_ok;
      MON_REF:  mon_d = ~main_ref_n;
      MON_AUX:  mon_d = aux_fb_n;
      MON_MAIN: mon_d = main_fb_n;
      default:  mon_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mon <= 1'b0;
    else     mon <= mon_d;
  end
endmodule

// File: rtl/pfd_dual_lock.sv
module pfd_dual_lock
  import pfd_pkg::*;
#(
  parameter int unsigned SKEW_LIMIT = 1,
  parameter int unsigned LOCK_COUNT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       main_en,
  input  logic       aux_en,
  input  logic       main_ref_div,
  input  logic       main_fb_div,
  input  logic       aux_ref_div,
  input  logic       aux_fb_div,
  input  logic [1:0] test_sel,
  output logic       main_up,
  output logic       main_dn,
  output logic       aux_up,
  output logic       aux_dn,
  output logic       lock_mon
);
  logic [NUM_LOOPS-1:0] en_v, ref_v, fb_v, up_v, dn_v, ok_v;

  assign en_v  = {aux_en, main_en};
  assign ref_v = {aux_ref_div, main_ref_div};
  assign fb_v  = {aux_fb_div, main_fb_div};

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    pfd_detector u_det (
      .clk   (clk),
      .rst   (rst),
      .en    (en_v[g]),
      .ref_n (ref_v[g]),
      .fb_n  (fb_v[g]),
      .up    (up_v[g]),
      .dn    (dn_v[g])
    );
    pfd_lock_meter #(
      .SKEW_LIMIT (SKEW_LIMIT),
      .LOCK_COUNT (LOCK_COUNT)
    ) u_meter (
      .clk     (clk),
      .rst     (rst),
      .en      (en_v[g]),
      .up      (up_v[g]),
      .dn      (dn_v[g]),
      .loop_ok (ok_v[g])
    );
  end

  pfd_mon_mux u_mux (
    .clk        (clk),
    .rst        (rst),
    .sel        (test_sel),
    .main_ok    (ok_v[LOOP_MAIN]),
    .aux_ok     (ok_v[LOOP_AUX]),
    .main_ref_n (main_ref_div),
    .aux_fb_n   (aux_fb_div),
    .main_fb_n  (main_fb_div),
    .mon        (lock_mon)
  );

  assign main_up = up_v[LOOP_MAIN];
  assign main_dn = dn_v[LOOP_MAIN];
  assign aux_up  = up_v[LOOP_AUX];
  assign aux_dn  = dn_v[LOOP_AUX];
endmodule

// File: rtl/pfd_dual_lock_chk.sv
module pfd_dual_lock_chk (
  input logic       clk,
  input logic       rst,
  input logic       main_en,
  input logic       aux_en,
  input logic       main_ref_div,
  input logic       main_fb_div,
  input logic [1:0] test_sel,
  input logic       main_up,
  input logic       main_dn,
  input logic       aux_up,
  input logic       aux_dn,
  input logic       lock_mon
);
  // R2
  main_pair_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (main_up && main_dn) |=> (!main_up && !main_dn));
  // R2
  aux_pair_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (aux_up && aux_dn) |=> (!aux_up && !aux_dn));
  // R3
  main_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !main_en |=> (!main_up && !main_dn));
  // R3
  aux_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !aux_en |=> (!aux_up && !aux_dn));
  // R6
  off_counts_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (test_sel == 2'b00 && !main_en && !aux_en) |=> lock_mon);
  // R7
  mon_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (test_sel == 2'b01) |=> (lock_mon == !$past(main_ref_div)));
  // R7
  mon_main_chk: assert property (@(posedge clk) disable iff (rst)
    (test_sel == 2'b11) |=> (lock_mon == $past(main_fb_div)));
endmodule

bind pfd_dual_lock pfd_dual_lock_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .main_en      (main_en),
  .aux_en       (aux_en),
  .main_ref_div (main_ref_div),
  .main_fb_div  (main_fb_div),
  .test_sel     (test_sel),
  .main_up      (main_up),
  .main_dn      (main_dn),
  .aux_up       (aux_up),
  .aux_dn       (aux_dn),
  .lock_mon     (lock_mon)
);

// File: tb/pfd_dual_lock_bench.sv
module pfd_dual_lock_bench;
  localparam int LIM = 1;
  localparam int LC  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic main_en = 1'b1, aux_en = 1'b1;
  logic main_ref_div = 1'b1, main_fb_div = 1'b1;
  logic aux_ref_div = 1'b1, aux_fb_div = 1'b1;
  logic [1:0] test_sel = 2'b00;
  logic main_up, main_dn, aux_up, aux_dn, lock_mon;

  always #2.5 clk = ~clk;

  pfd_dual_lock #(.SKEW_LIMIT(LIM), .LOCK_COUNT(LC)) u_pfd_dual_lock (
    .clk(clk), .rst(rst), .main_en(main_en), .aux_en(aux_en),
    .main_ref_div(main_ref_div), .main_fb_div(main_fb_div),
    .aux_ref_div(aux_ref_div), .aux_fb_div(aux_fb_div),
    .test_sel(test_sel), .main_up(main_up), .main_dn(main_dn),
    .aux_up(aux_up), .aux_dn(aux_dn), .lock_mon(lock_mon));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string phase = "R8";

  // behavioural model state, index 0 = main, 1 = aux
  int p_ref[2], p_fb[2], m_up[2], m_dn[2], m_w[2], m_s[2], m_l[2];
  int m_mon;

  function automatic void chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endfunction

  function automatic void model_reset();
    for (int l = 0; l < 2; l++) begin
      p_ref[l] = 1; p_fb[l] = 1; m_up[l] = 0; m_dn[l] = 0;
      m_w[l] = 0; m_s[l] = 0; m_l[l] = 0;
    end
    m_mon = 0;
  endfunction

  function automatic void model_step();
    int rin[2], fin[2], en[2];
    int ok[2];
    rin = '{int'(main_ref_div), int'(aux_ref_div)};
    fin = '{int'(main_fb_div), int'(aux_fb_div)};
    en  = '{int'(main_en), int'(aux_en)};
    if (rst) begin model_reset(); return; end
    for (int l = 0; l < 2; l++) ok[l] = (m_l[l] != 0 || en[l] == 0) ? 1 : 0;
    case (test_sel)
      2'b00: m_mon = ok[0] & ok[1];
      2'b01: m_mon = (rin[0] == 0) ? 1 : 0;
      2'b10: m_mon = fin[1];
      default: m_mon = fin[0];
    endcase
    for (int l = 0; l < 2; l++) begin
      int both, one, nu, nd, nw, ns, nl;
      both = (m_up[l] != 0 && m_dn[l] != 0);
      one  = (m_up[l] != m_dn[l]);
      if (en[l] == 0) begin
        nu = 0; nd = 0; nw = 0; ns = 0; nl = 0;
      end else begin
        nu = both ? 0 : ((m_up[l] != 0 || (p_ref[l] == 1 && rin[l] == 0)) ? 1 : 0);
        nd = both ? 0 : ((m_dn[l] != 0 || (p_fb[l] == 1 && fin[l] == 0)) ? 1 : 0);
        nw = both ? 0 : ((one && m_w[l] < LIM) ? m_w[l] + 1 : m_w[l]);
        ns = m_s[l]; nl = m_l[l];
        if (m_w[l] >= LIM) begin ns = 0; nl = 0; end
        else if (both) begin
          ns = (m_s[l] + 1 > LC) ? LC : m_s[l] + 1;
          nl = (ns == LC) ? 1 : 0;
        end
      end
      m_up[l] = nu; m_dn[l] = nd; m_w[l] = nw; m_s[l] = ns; m_l[l] = nl;
      p_ref[l] = rin[l]; p_fb[l] = fin[l];
    end
  endfunction

  // inputs are set at a falling edge; the model steps, then sampling happens at the next falling edge
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(phase, "main_up", main_up, m_up[0]);
    chk(phase, "main_dn", main_dn, m_dn[0]);
    chk(phase, "aux_up", aux_up, m_up[1]);
    chk(phase, "aux_dn", aux_dn, m_dn[1]);
    chk(phase, "lock_mon", lock_mon, m_mon);
  endtask

  // periods of length per; feedback pulse delayed by dm (main) and da (aux)
  task automatic run(int n, int per, int dm, int da, bit aux_fb_on);
    for (int k = 0; k < n; k++)
      for (int c = 0; c < per; c++) begin
        main_ref_div = (c != 0);
        aux_ref_div  = (c != 0);
        main_fb_div  = (c != dm);
        aux_fb_div   = aux_fb_on ? (c != da) : 1'b1;
        tick();
      end
  endtask

  task automatic idle(int n);
    main_ref_div = 1; main_fb_div = 1; aux_ref_div = 1; aux_fb_div = 1;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    model_reset();
    repeat (3) tick();
    rst = 0;
    // R8 reset state
    chk("R8", "main_up", main_up, 0); chk("R8", "main_dn", main_dn, 0);
    chk("R8", "aux_up", aux_up, 0);   chk("R8", "lock_mon", lock_mon, 0);
    idle(2);

    // R1 single reference edge sets up only
    phase = "R1";
    main_ref_div = 0; tick();
    chk("R1", "main_up", main_up, 1); chk("R1", "main_dn", main_dn, 0);
    main_ref_div = 1; tick();
    // R2 feedback edge makes both high for one cycle, then both clear
    phase = "R2";
    main_fb_div = 0; tick();
    chk("R2", "main_dn", main_dn, 1); chk("R2", "main_up", main_up, 1);
    main_fb_div = 1; main_ref_div = 0; tick();   // edge lands in the clearing cycle
    chk("R2", "main_up cleared", main_up, 0); chk("R2", "main_dn cleared", main_dn, 0);
    main_ref_div = 1; tick();
    chk("R2", "dropped edge main_up", main_up, 0);
    idle(3);

    // R4 aligned loops reach lock
    phase = "R4";
    run(8, 8, 0, 0, 1);
    chk("R4", "lock after aligned run", lock_mon, 1);
    // R4 skew of one cycle inside the limit is not allowed at default (width 1 == limit)
    phase = "R5";
    run(2, 8, 1, 0, 1);
    chk("R5", "lock lost on skew", lock_mon, 0);
    run(8, 8, 0, 0, 1);
    chk("R4", "relock", lock_mon, 1);
    // R5 aux feedback stops: lock drops without the other edge
    run(2, 8, 0, 0, 0);
    chk("R5", "lock lost on missing edge", lock_mon, 0);
    // fb leading the reference
    phase = "R1";
    run(4, 8, 6, 5, 1);

    // R3 disabled main loop ignores its inputs; R6 disabled counts as locked
    phase = "R3";
    run(8, 8, 0, 0, 1);
    main_en = 0;
    run(4, 8, 3, 0, 1);
    chk("R3", "main_up off", main_up, 0); chk("R3", "main_dn off", main_dn, 0);
    chk("R6", "disabled main counts locked", lock_mon, 1);
    aux_en = 0; phase = "R6";
    run(2, 6, 2, 4, 1);
    chk("R6", "both disabled", lock_mon, 1);
    main_en = 1; aux_en = 1;
    run(2, 8, 0, 0, 1);
    chk("R6", "re-enabled not yet locked", lock_mon, 0);

    // R7 monitor selections
    phase = "R7";
    test_sel = 2'b01; main_ref_div = 0; tick(); tick();
    chk("R7", "ref inverted", lock_mon, 1);
    main_ref_div = 1; tick();
    chk("R7", "ref idle", lock_mon, 0);
    test_sel = 2'b10; aux_fb_div = 0; tick();
    chk("R7", "aux fb low", lock_mon, 0);
    aux_fb_div = 1; tick();
    chk("R7", "aux fb idle", lock_mon, 1);
    test_sel = 2'b11; main_fb_div = 0; tick();
    chk("R7", "main fb low", lock_mon, 0);
    main_fb_div = 1; tick();
    for (int s = 1; s < 4; s++) begin
      test_sel = 2'(s);
      run(3, 7, 2, 3, 1);
    end
    test_sel = 2'b00;
    run(6, 8, 0, 0, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule